// File: doc/BRIEF.md
# ECC Background Scrub Engine

This block holds a small array of codewords protected by a single-error-correct, double-error-detect code. It also walks through that array in the background, one word at a time. Each pulse of a periodic refresh tick asks the engine to check one word. The engine reads the codeword and decodes it. If exactly one bit is wrong, it writes the repaired codeword back. Faults are therefore found and removed before a second, independent upset can land in the same rarely-read word and make it unrecoverable.

A requester reaches the same array through a valid/ready port. The port takes normal writes, which the block encodes, and normal reads, which return corrected data. It also takes raw writes and raw reads, which move whole codewords for diagnostics. The requester always wins the single memory port, and scrub steps fill the idle cycles. `req_ready` is held high: every offered request is taken in the cycle it is offered, so the requester never sees back-pressure. A read answers one cycle later on `rsp_valid`. The response path has no ready signal, and the requester must take the response in that cycle.

Two saturating counters track scrub results separately: one for words that were corrected and one for words that could not be. A latched address and a sticky flag report the most recent uncorrectable word.

Top module: `ecc_scrub_engine`

## Requirements
- R1: Each `refresh_tick` pulse requests a scrub of exactly one word. Scrubbed addresses run in ascending order from 0 after reset and wrap from DEPTH-1 to 0. A scrub read starts in the first cycle in which a request is pending and `req_valid` is low.
- R2: Whenever `req_valid` is high, the requester gets the memory port. No scrub read or write-back happens in that cycle, so a word stays unscrubbed for as long as the requester holds the port.
- R3: At most one scrub request is kept pending. Any number of ticks that arrive while a scrub is pending or deferred result in a single scrubbed word.
- R4: When a scrubbed word holds a single-bit error, the engine writes the corrected codeword back to the same address and increments `corr_count`.
- R5: When a scrubbed word holds a double-bit error, the engine does not write back. It increments `uncorr_count` and latches the word's address on `bad_addr`.
- R6: A double-bit error found by a scrub sets `uncorr_irq`. The flag stays set until `irq_clear` is pulsed, and a new error arriving in the same cycle as the clear wins.
- R7: A requester write to the word under scrub, arriving after the scrub read but before the write-back, cancels the write-back. The requester's data remains in the array.
- R8: `pass_done` pulses for one cycle each time the scrub address wraps from DEPTH-1 to 0.
- R9: `corr_count` and `uncorr_count` are CNT_W bits wide (16 by default). Each stops at its all-ones value and does not wrap.
- R10: A read, normal or raw, returns the stored codeword on `rsp_code` and the corrected data on `rsp_data`, with `rsp_valid` high in the next cycle. After reset both counters, `uncorr_irq` and `rsp_valid` are 0 and the array holds all-zero codewords.
- R11: Codeword layout: bit 0 is overall parity, bits at power-of-two indexes are Hamming check bits, and data bits fill the remaining indexes in ascending order. A single flip in any bit, including bit 0 and the check bits, is corrected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_tick | input | 1 | One-cycle pulse requesting one scrub step |
| req_valid | input | 1 | Requester access offered |
| req_ready | output | 1 | Access accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_raw | input | 1 | Write stores `req_wcode` as given instead of encoding `req_wdata` |
| req_addr | input | AW | Word address |
| req_wdata | input | DATA_W | Write data for an encoded write |
| req_wcode | input | CODE_W | Codeword for a raw write |
| rsp_valid | output | 1 | Read response present |
| rsp_data | output | DATA_W | Corrected read data |
| rsp_code | output | CODE_W | Stored codeword as read |
| pass_done | output | 1 | Pulse on scrub address wrap |
| corr_count | output | CNT_W | Saturating count of corrected words |
| uncorr_count | output | CNT_W | Saturating count of uncorrectable words |
| bad_addr | output | AW | Address of the latest uncorrectable word |
| uncorr_irq | output | 1 | Sticky uncorrectable-error flag |
| irq_clear | input | 1 | Clears `uncorr_irq` |

## Verification
The scrub address is internal, so a wrong address step shows up at the ports only when the word that gets repaired is not the word the ticks predicted. A raw read of the neighbouring corrupted words shows this a few cycles after the tick. A stuck pending flag makes extra words heal after a burst of ticks, and the next raw read reveals it. A write-back that was not cancelled changes the data returned by the requester's next read. Counter or flag errors show directly on `corr_count`, `uncorr_count` and `uncorr_irq` within three cycles of the scrub read.

// File: rtl/ecc_scrub_pkg.sv
package ecc_scrub_pkg;

  // Number of Hamming check bits needed to cover dw data bits.
  function automatic int chk_bits(input int dw);
    for (int p = 1; p < 31; p++) begin
      if ((1 << p) >= dw + p + 1) return p;
    end
    return 31;
  endfunction

  typedef enum logic [1:0] {SQ_IDLE, SQ_CHECK, SQ_WB} sq_state_t;

  typedef enum logic [1:0] {EC_CLEAN, EC_FIXED, EC_FATAL} ecc_verdict_t;

endpackage

// File: rtl/scrub_secded_enc.sv
module scrub_secded_enc
  import ecc_scrub_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int P     = chk_bits(DATA_W),
  localparam int CW    = DATA_W + P + 1
) (
  input  logic [DATA_W-1:0] data,
  output logic [CW-1:0]     code
);

  always_comb begin
    logic [CW-1:0] c;
    int k;
    logic par;
    c = '0;
    k = 0;
    // scatter data into non power-of-two positions
    for (int i = 1; i < CW; i++) begin
      if ((i & (i - 1)) != 0) begin
        c[i] = data[k];
        k++;
      end
    end
    // check bit j covers every position with bit j of its index set
    for (int j = 0; j < P; j++) begin
      par = 1'b0;
      for (int i = 1; i < CW; i++) begin
        if (((i >> j) & 1) == 1) par = par ^ c[i];
      end
      c[1 << j] = par;
    end
    c[0] = ^c[CW-1:1];
    code = c;
  end

endmodule

// File: rtl/scrub_secded_dec.sv
module scrub_secded_dec
  import ecc_scrub_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int P     = chk_bits(DATA_W),
  localparam int CW    = DATA_W + P + 1
) (
  input  logic [CW-1:0]     code,
  output logic [CW-1:0]     fixed_code,
  output logic [DATA_W-1:0] data,
  output ecc_verdict_t      verdict
);

  logic [P-1:0] syn;
  logic         ovr;

  always_comb begin
    syn = '0;
    for (int i = 1; i < CW; i++) begin
      if (code[i]) syn = syn ^ P'(i);
    end
    ovr = ^code;
  end

  always_comb begin
    fixed_code = code;
    verdict    = EC_CLEAN;
    if (ovr) begin
      if (syn == '0) begin
        fixed_code[0] = ~code[0];
        verdict       = EC_FIXED;
      end else if (int'(syn) < CW) begin
        fixed_code[syn] = ~code[syn];
        verdict         = EC_FIXED;
      end else begin
        verdict = EC_FATAL;
      end
    end else if (syn != '0) begin
      verdict = EC_FATAL;
    end
  end

  always_comb begin
    int k;
    data = '0;
    k = 0;
    for (int i = 1; i < CW; i++) begin
      if ((i & (i - 1)) != 0) begin
        data[k] = fixed_code[i];
        k++;
      end
    end
  end

endmodule

// File: rtl/scrub_store.sv
module scrub_store #(
  parameter int DEPTH  = 16,
  parameter int CW     = 13,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wcode,
  output logic [CW-1:0] q
);

  logic [CW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      q <= '0;
    end else if (en) begin
      if (we) mem[addr] <= wcode;
      else    q         <= mem[addr];
    end
  end

endmodule

// File: rtl/scrub_seq.sv
module scrub_seq
  import ecc_scrub_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int CW     = 13,
  parameter int CNT_W  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refresh_tick,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  ecc_verdict_t     verdict,
  input  logic [CW-1:0]    fixed_code,
  input  logic             irq_clear,
  output logic             scrub_rd,
  output logic             scrub_wr,
  output logic [AW-1:0]    scrub_addr,
  output logic [CW-1:0]    wb_code,
  output logic             pass_done,
  output logic [CNT_W-1:0] corr_cnt,
  output logic [CNT_W-1:0] uncorr_cnt,
  output logic [AW-1:0]    bad_addr,
  output logic             uncorr_irq
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [AW-1:0]    LAST    = AW'(DEPTH - 1);

  sq_state_t st;
  logic      pend;
  logic      clash;
  logic      finish;
  logic      in_check;

  always_comb begin
    in_check = (st == SQ_CHECK);
    clash    = req_valid && req_write && (req_addr == scrub_addr);
    scrub_rd = (st == SQ_IDLE) && pend && !req_valid;
    scrub_wr = (st == SQ_WB) && !req_valid;
    finish   = (in_check && ((verdict != EC_FIXED) || clash)) ||
               ((st == SQ_WB) && (!req_valid || clash));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= SQ_IDLE;
      pend       <= 1'b0;
      scrub_addr <= '0;
      wb_code    <= '0;
      pass_done  <= 1'b0;
      corr_cnt   <= '0;
      uncorr_cnt <= '0;
      bad_addr   <= '0;
      uncorr_irq <= 1'b0;
    end else begin
      if (refresh_tick)  pend <= 1'b1;
      else if (scrub_rd) pend <= 1'b0;

      case (st)
        SQ_IDLE:  if (scrub_rd) st <= SQ_CHECK;
        SQ_CHECK: begin
          if (finish) st <= SQ_IDLE;
          else begin
            st      <= SQ_WB;
            wb_code <= fixed_code;
          end
        end
        SQ_WB:    if (finish) st <= SQ_IDLE;
        default:  st <= SQ_IDLE;
      endcase

      pass_done <= 1'b0;
      if (finish) begin
        if (scrub_addr == LAST) begin
          scrub_addr <= '0;
          pass_done  <= 1'b1;
        end else begin
          scrub_addr <= scrub_addr + 1'b1;
        end
      end

      if (in_check && verdict == EC_FIXED && corr_cnt != CNT_MAX)
        corr_cnt <= corr_cnt + 1'b1;
      if (in_check && verdict == EC_FATAL) begin
        if (uncorr_cnt != CNT_MAX) uncorr_cnt <= uncorr_cnt + 1'b1;
        bad_addr <= scrub_addr;
      end

      if (in_check && verdict == EC_FATAL) uncorr_irq <= 1'b1;
      else if (irq_clear)                  uncorr_irq <= 1'b0;
    end
  end

  a_r1_scrub_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_IDLE && pend && !req_valid) |=> (st == SQ_CHECK));

  a_r7_clash_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_CHECK && clash) |=> (st == SQ_IDLE));

  a_r8_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |-> (scrub_addr == '0));

  a_r9_corr_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_cnt == CNT_MAX) |=> (corr_cnt == CNT_MAX));

  a_r9_uncorr_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (uncorr_cnt == CNT_MAX) |=> (uncorr_cnt == CNT_MAX));

  a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (uncorr_irq && !irq_clear) |=> uncorr_irq);

endmodule

// File: rtl/ecc_scrub_engine.sv
module ecc_scrub_engine
  import ecc_scrub_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 16,
  localparam int CODE_W = DATA_W + chk_bits(DATA_W) + 1,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refresh_tick,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_raw,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CODE_W-1:0] req_wcode,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [CODE_W-1:0] rsp_code,
  output logic              pass_done,
  output logic [CNT_W-1:0]  corr_count,
  output logic [CNT_W-1:0]  uncorr_count,
  output logic [AW-1:0]     bad_addr,
  output logic              uncorr_irq,
  input  logic              irq_clear
);

  logic [CODE_W-1:0] enc_code;
  logic [CODE_W-1:0] rd_q;
  logic [CODE_W-1:0] fix_code;
  logic [CODE_W-1:0] wb_code;
  ecc_verdict_t      verdict;
  logic              scrub_rd;
  logic              scrub_wr;
  logic [AW-1:0]     scrub_addr;
  logic              mem_en;
  logic              mem_we;
  logic [AW-1:0]     mem_addr;
  logic [CODE_W-1:0] mem_wcode;

  assign req_ready = 1'b1;

  scrub_secded_enc #(.DATA_W(DATA_W)) u_enc (
    .data (req_wdata),
    .code (enc_code)
  );

  scrub_secded_dec #(.DATA_W(DATA_W)) u_dec (
    .code       (rd_q),
    .fixed_code (fix_code),
    .data       (rsp_data),
    .verdict    (verdict)
  );

  scrub_seq #(.DEPTH(DEPTH), .CW(CODE_W), .CNT_W(CNT_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .refresh_tick (refresh_tick),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .verdict      (verdict),
    .fixed_code   (fix_code),
    .irq_clear    (irq_clear),
    .scrub_rd     (scrub_rd),
    .scrub_wr     (scrub_wr),
    .scrub_addr   (scrub_addr),
    .wb_code      (wb_code),
    .pass_done    (pass_done),
    .corr_cnt     (corr_count),
    .uncorr_cnt   (uncorr_count),
    .bad_addr     (bad_addr),
    .uncorr_irq   (uncorr_irq)
  );

  // requester first, then scrub read or write-back
  always_comb begin
    mem_en    = req_valid || scrub_rd || scrub_wr;
    mem_we    = req_valid ? req_write : scrub_wr;
    mem_addr  = req_valid ? req_addr  : scrub_addr;
    mem_wcode = req_valid ? (req_raw ? req_wcode : enc_code) : wb_code;
  end

  scrub_store #(.DEPTH(DEPTH), .CW(CODE_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (mem_en),
    .we    (mem_we),
    .addr  (mem_addr),
    .wcode (mem_wcode),
    .q     (rd_q)
  );

  assign rsp_code = rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= req_valid && !req_write;
  end

  a_r2_req_first: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !(scrub_rd || scrub_wr));

endmodule

// File: tb/tb_ecc_scrub_engine.sv
module tb_ecc_scrub_engine;

  localparam int CLK_PERIOD = 10;
  localparam int DW  = 8;
  localparam int DEP = 8;
  localparam int CNW = 4;
  localparam int CW  = 13;
  localparam int AW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic refresh_tick = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_raw = 1'b0, irq_clear = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [CW-1:0] req_wcode = '0;
  logic req_ready, rsp_valid, pass_done, uncorr_irq;
  logic [DW-1:0] rsp_data;
  logic [CW-1:0] rsp_code;
  logic [CNW-1:0] corr_count, uncorr_count;
  logic [AW-1:0] bad_addr;

  int n_chk = 0, n_fail = 0, n_pass = 0;
  int sa = 0;
  int exp_corr = 0, exp_unc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_scrub_engine #(.DATA_W(DW), .DEPTH(DEP), .CNT_W(CNW)) dut (
    .clk(clk), .rst_n(rst_n), .refresh_tick(refresh_tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_raw(req_raw), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_wcode(req_wcode), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_code(rsp_code), .pass_done(pass_done), .corr_count(corr_count),
    .uncorr_count(uncorr_count), .bad_addr(bad_addr),
    .uncorr_irq(uncorr_irq), .irq_clear(irq_clear)
  );

  // addr[25:23] data[22:15] flip[14:2] kind[1:0]: 0 clean, 1 single, 2 double
  localparam logic [25:0] VECS [12] = '{
    {3'd0, 8'hA5, 13'h0000, 2'd0},
    {3'd1, 8'h3C, 13'h0001, 2'd1},
    {3'd2, 8'hFF, 13'h0002, 2'd1},
    {3'd3, 8'h00, 13'h0080, 2'd1},
    {3'd4, 8'h81, 13'h0208, 2'd2},
    {3'd5, 8'h5A, 13'h1000, 2'd1},
    {3'd6, 8'h77, 13'h0010, 2'd1},
    {3'd7, 8'hC3, 13'h0000, 2'd0},
    {3'd0, 8'h10, 13'h0040, 2'd1},
    {3'd1, 8'hE7, 13'h1020, 2'd2},
    {3'd2, 8'h2B, 13'h0400, 2'd1},
    {3'd3, 8'h99, 13'h0004, 2'd1}
  };

  always @(negedge clk) if (rst_n && pass_done) n_pass++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic raw, input int a,
                        input logic [DW-1:0] d, input logic [CW-1:0] c,
                        output logic [CW-1:0] co, output logic [DW-1:0] dout,
                        output logic vo);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_raw = raw;
    req_addr = AW'(a); req_wdata = d; req_wcode = c;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_raw = 1'b0;
    co = rsp_code; dout = rsp_data; vo = rsp_valid;
  endtask

  task automatic tick_and_wait();
    @(negedge clk); refresh_tick = 1'b1;
    @(negedge clk); refresh_tick = 1'b0;
    repeat (6) @(negedge clk);
    sa = (sa + 1) % DEP;
  endtask

  // write data, then corrupt the stored codeword; returns the clean codeword
  task automatic plant(input int a, input logic [DW-1:0] d,
                       input logic [CW-1:0] flip, output logic [CW-1:0] good);
    logic [CW-1:0] co; logic [DW-1:0] dd; logic v;
    access(1'b1, 1'b0, a, d, '0, co, dd, v);
    access(1'b0, 1'b1, a, '0, '0, good, dd, v);
    if (flip != '0) access(1'b1, 1'b1, a, '0, good ^ flip, co, dd, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] good, good2, co;
    logic [DW-1:0] dd;
    logic v;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 reset corr", 32'(corr_count), 0);
    check("R10 reset uncorr", 32'(uncorr_count), 0);
    check("R10 reset irq", 32'(uncorr_irq), 0);
    check("R10 reset rsp_valid", 32'(rsp_valid), 0);

    // R1 R4 R5 R11: one scrub per tick, ascending addresses
    for (int i = 0; i < 12; i++) begin
      logic [25:0] vv;
      vv = VECS[i];
      plant(int'(vv[25:23]), vv[22:15], vv[14:2], good);
      tick_and_wait();
      if (vv[1:0] == 2'd1) exp_corr++;
      if (vv[1:0] == 2'd2) exp_unc++;
      access(1'b0, 1'b1, int'(vv[25:23]), '0, '0, co, dd, v);
      if (vv[1:0] == 2'd1) check("R4 R11 repaired codeword", 32'(co), 32'(good));
      else                 check("R5 no write-back / clean kept", 32'(co), 32'(good ^ vv[14:2]));
      if (vv[1:0] != 2'd2) begin
        access(1'b0, 1'b0, int'(vv[25:23]), '0, '0, co, dd, v);
        check("R10 corrected data", 32'(dd), 32'(vv[22:15]));
        check("R10 rsp_valid", 32'(v), 1);
      end
      check("R1 R4 corr_count", 32'(corr_count), 32'(exp_corr));
      check("R5 uncorr_count", 32'(uncorr_count), 32'(exp_unc));
    end
    check("R8 one wrap after 12 scrubs", 32'(n_pass), 1);
    check("R5 bad_addr", 32'(bad_addr), 1);

    // R6 sticky flag
    check("R6 irq set", 32'(uncorr_irq), 1);
    repeat (5) @(negedge clk);
    check("R6 irq holds", 32'(uncorr_irq), 1);
    @(negedge clk); irq_clear = 1'b1;
    @(negedge clk); irq_clear = 1'b0;
    check("R6 irq cleared", 32'(uncorr_irq), 0);

    // R9 saturation of corr_count
    for (int k = 0; k < 9; k++) begin
      plant(sa, 8'(k * 17 + 3), 13'h0008, good);
      tick_and_wait();
    end
    check("R9 corr_count saturates", 32'(corr_count), 15);
    check("R8 second wrap", 32'(n_pass), 2);

    // R2 R3: requester holds the port while three ticks arrive
    plant(sa, 8'h6E, 13'h0100, good);
    plant((sa + 1) % DEP, 8'hD1, 13'h0100, good2);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_raw = 1'b1; req_addr = AW'(sa);
    for (int t = 0; t < 3; t++) begin
      @(negedge clk); refresh_tick = 1'b1;
      @(negedge clk); refresh_tick = 1'b0;
    end
    @(negedge clk);
    check("R2 word untouched while requester holds port", 32'(rsp_code), 32'(good ^ 13'h0100));
    req_valid = 1'b0; req_raw = 1'b0;
    repeat (10) @(negedge clk);
    access(1'b0, 1'b1, sa, '0, '0, co, dd, v);
    check("R3 first word scrubbed", 32'(co), 32'(good));
    access(1'b0, 1'b1, (sa + 1) % DEP, '0, '0, co, dd, v);
    check("R3 second word not scrubbed", 32'(co), 32'(good2 ^ 13'h0100));
    sa = (sa + 1) % DEP;

    // R7 requester write lands between scrub read and write-back
    plant(sa, 8'h44, 13'h0020, good);
    @(negedge clk); refresh_tick = 1'b1;
    @(negedge clk); refresh_tick = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_raw = 1'b0;
    req_addr = AW'(sa); req_wdata = 8'hB8;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    repeat (6) @(negedge clk);
    access(1'b0, 1'b0, sa, '0, '0, co, dd, v);
    check("R7 newer write kept", 32'(dd), 32'hB8);
    sa = (sa + 1) % DEP;

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule